// File: doc/BRIEF.md
# Latched Serial Word Receiver for a Converter Core

This block is the digital input stage of a serial-fed audio converter. A serial data line is sampled on every rising edge of the bit clock and shifted into an 18-bit register, most significant bit first. The words are two's complement. The sender may put any number of filler bits ahead of a word. When the latch-enable line goes from high to low, the 18 bits shifted most recently are copied into a parallel holding register. That register drives the converter core. A one-cycle strobe marks each copy.

The latch-enable line has a dwell rule. It must be seen high on at least two consecutive clock edges before it drops. After it drops, it must be seen low on at least two consecutive clock edges before it rises again. A shorter dwell does not stop the transfer. It raises a one-cycle violation flag, one flag for each direction. Everything runs in the bit-clock domain.

Top module: `sdac_frontend`

## Requirements
- R1: On each rising clock edge one `ser_data` bit enters the shift register. After a transfer, `word_out[17]` holds the earliest of the 18 transferred bits and `word_out[0]` holds the latest.
- R2: Only the 18 bits shifted in before the falling-edge sample are transferred. Any earlier bits, however many there are, are discarded.
- R3: A falling edge is detected when `latch_en` is sampled low on an edge after being sampled high on the previous edge. `word_out` takes the new word and `word_valid` is high in the cycle after that edge. The bit shifted on that same edge is not part of the word.
- R4: `word_out` holds its value while no falling edge is detected. This applies when `latch_en` stays low across many shifted bits and when it stays high across many shifted bits.
- R5: `le_high_short` pulses for one cycle, together with `word_valid`, when `latch_en` falls after being sampled high on fewer than 2 consecutive edges. The word is still transferred.
- R6: `le_low_short` pulses for one cycle, after the edge where a rise is seen, when `latch_en` rises after being sampled low on fewer than 2 consecutive edges.
- R7: A synchronous active-high `rst` clears `word_out` to 0x00000 (bipolar zero). It also clears `word_valid`, `le_high_short` and `le_low_short`. The latch-enable history after reset counts as a long dwell, so a rise on the first edges after reset raises no flag.
- R8: `word_valid` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all sampling on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ser_data | input | 1 | Serial data, MSB first, two's complement |
| latch_en | input | 1 | Latch enable; a high-to-low transition transfers the word |
| word_out | output | 18 | Parallel word presented to the converter core |
| word_valid | output | 1 | One-cycle strobe on each update of `word_out` |
| le_high_short | output | 1 | Latch enable fell after too short a high dwell |
| le_low_short | output | 1 | Latch enable rose after too short a low dwell |

## Verification
A wrong shift-register bit shows up as a wrong `word_out` value in the cycle after the next detected fall. The symptom waits for that fall and never appears earlier. A wrong stored latch-enable level shows up in two ways. It can make a phantom or missing `word_valid` strobe one cycle after the edge. It can also make `word_out` change while the line is held steady. A dwell counter that is off by one makes a violation flag appear on a legal dwell, or stay silent on a one-edge dwell, in the cycle after the transition. The scoreboard compares each strobe against the queued word and the queued high-dwell flag. It also compares the total count of low-dwell flags with the number the driver produced on purpose.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    localparam int unsigned WORD_BITS_DEF  = 18;
    localparam int unsigned MIN_DWELL_DEF  = 2;

    // Transition seen on latch enable at the current edge
    typedef enum logic [1:0] {
        LE_HOLD = 2'd0,
        LE_FALL = 2'd1,
        LE_RISE = 2'd2
    } le_evt_t;

    // Dwell-rule violation pair
    typedef struct packed {
        logic high_short;
        logic low_short;
    } dwell_err_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
    parameter int unsigned WORD_BITS = 18
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ser_in,
    output logic [WORD_BITS-1:0] shreg
);

    // Oldest bit moves toward the top; newest enters at bit 0
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[WORD_BITS-2:0], ser_in};
        end
    end

endmodule

// File: rtl/sdac_le_monitor.sv
module sdac_le_monitor
    import sdac_pkg::*;
#(
    parameter int unsigned MIN_HIGH_EDGES = 2,
    parameter int unsigned MIN_LOW_EDGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       le_in,
    output le_evt_t    evt,
    output dwell_err_t err_q
);

    localparam int unsigned RUN_MAX = max2(max2(MIN_HIGH_EDGES, MIN_LOW_EDGES), 1);
    localparam int unsigned RUN_W   = $clog2(RUN_MAX + 1);

    logic             le_prev;
    logic [RUN_W-1:0] run_len;

    always_comb begin
        if (le_prev && !le_in) begin
            evt = LE_FALL;
        end else if (!le_prev && le_in) begin
            evt = LE_RISE;
        end else begin
            evt = LE_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            le_prev <= 1'b0;
            run_len <= RUN_W'(RUN_MAX);
            err_q   <= '0;
        end else begin
            le_prev <= le_in;
            err_q   <= '0;
            unique case (evt)
                LE_FALL: begin
                    err_q.high_short <= (run_len < RUN_W'(MIN_HIGH_EDGES));
                    run_len          <= RUN_W'(1);
                end
                LE_RISE: begin
                    err_q.low_short  <= (run_len < RUN_W'(MIN_LOW_EDGES));
                    run_len          <= RUN_W'(1);
                end
                default: begin
                    if (run_len != RUN_W'(RUN_MAX)) begin
                        run_len <= run_len + RUN_W'(1);
                    end
                end
            endcase
        end
    end

    AST_HIGH_SHORT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        err_q.high_short |-> (!$past(le_in) && $past(le_in, 2))); // R5

    AST_LOW_SHORT_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        err_q.low_short |-> ($past(le_in) && !$past(le_in, 2))); // R6

endmodule

// File: rtl/sdac_word_latch.sv
module sdac_word_latch #(
    parameter int unsigned WORD_BITS = 18
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [WORD_BITS-1:0] word_in,
    output logic [WORD_BITS-1:0] word_out,
    output logic                 word_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= load;
            if (load) begin
                word_out <= word_in;
            end
        end
    end

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid); // R8

endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend
    import sdac_pkg::*;
#(
    parameter int unsigned WORD_BITS      = WORD_BITS_DEF,
    parameter int unsigned MIN_HIGH_EDGES = MIN_DWELL_DEF,
    parameter int unsigned MIN_LOW_EDGES  = MIN_DWELL_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ser_data,
    input  logic                 latch_en,
    output logic [WORD_BITS-1:0] word_out,
    output logic                 word_valid,
    output logic                 le_high_short,
    output logic                 le_low_short
);

    logic [WORD_BITS-1:0] shreg;
    le_evt_t              le_evt;
    dwell_err_t           dwell_err;

    sdac_shifter #(.WORD_BITS(WORD_BITS)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .ser_in (ser_data),
        .shreg  (shreg)
    );

    sdac_le_monitor #(
        .MIN_HIGH_EDGES (MIN_HIGH_EDGES),
        .MIN_LOW_EDGES  (MIN_LOW_EDGES)
    ) u_mon (
        .clk   (clk),
        .rst   (rst),
        .le_in (latch_en),
        .evt   (le_evt),
        .err_q (dwell_err)
    );

    sdac_word_latch #(.WORD_BITS(WORD_BITS)) u_latch (
        .clk        (clk),
        .rst        (rst),
        .load       (le_evt == LE_FALL),
        .word_in    (shreg),
        .word_out   (word_out),
        .word_valid (word_valid)
    );

    assign le_high_short = dwell_err.high_short;
    assign le_low_short  = dwell_err.low_short;

    AST_VALID_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> ($past(latch_en, 2) && !$past(latch_en))); // R3

    AST_LSB_LAST_BIT: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> (word_out[0] == $past(ser_data, 2))); // R1

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !word_valid |-> $stable(word_out)); // R4

    AST_HIGH_SHORT_WITH_LOAD: assert property (@(posedge clk) disable iff (rst)
        le_high_short |-> word_valid); // R5

endmodule

// File: tb/test_sdac_frontend.sv
module test_sdac_frontend;

    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ser_data = 1'b0;
    logic         latch_en = 1'b0;
    logic [W-1:0] word_out;
    logic         word_valid;
    logic         le_high_short;
    logic         le_low_short;

    int n_checks = 0;
    int n_errors = 0;
    int lo_expected = 0;
    int lo_seen = 0;
    bit prev_valid = 1'b0;

    typedef struct {
        logic [W-1:0] word;
        bit           hi_err;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    sdac_frontend i_sdac_frontend (
        .clk           (clk),
        .rst           (rst),
        .ser_data      (ser_data),
        .latch_en      (latch_en),
        .word_out      (word_out),
        .word_valid    (word_valid),
        .le_high_short (le_high_short),
        .le_low_short  (le_low_short)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b, input logic le);
        @(negedge clk);
        ser_data = b;
        latch_en = le;
    endtask

    // extra filler bits (LE low), then the word; LE high on the last hi_len bits
    task automatic send_word(input logic [W-1:0] w, input int extra, input int hi_len, input bit hi_err);
        exp_t e;
        for (int i = 0; i < extra; i++) shift_bit(1'($urandom), 1'b0);
        for (int i = 0; i < W; i++) shift_bit(w[W-1-i], (i >= W - hi_len));
        e.word   = w;
        e.hi_err = hi_err;
        sb_q.push_back(e);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (le_low_short) lo_seen++;
            if (word_valid) begin
                check(!prev_valid, "R8 strobe longer than one cycle", 32'(prev_valid), 32'd0);
                if (sb_q.size() == 0) begin
                    check(1'b0, "R4 unexpected word_valid", 32'(word_out), 32'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(word_out == e.word, "R1/R2/R3 word_out", 32'(word_out), 32'(e.word));
                    check(le_high_short == e.hi_err, "R5 le_high_short", 32'(le_high_short), 32'(e.hi_err));
                end
            end else begin
                if (le_high_short) check(1'b0, "R5 high flag without strobe", 32'd1, 32'd0);
            end
            prev_valid = word_valid;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [W-1:0] held;
        repeat (3) @(negedge clk);
        // R7 reset state
        check(word_out == '0, "R7 word_out at reset", 32'(word_out), 32'd0);
        check(word_valid == 1'b0, "R7 word_valid at reset", 32'(word_valid), 32'd0);
        check(le_high_short == 1'b0, "R7 le_high_short at reset", 32'(le_high_short), 32'd0);
        check(le_low_short == 1'b0, "R7 le_low_short at reset", 32'(le_low_short), 32'd0);
        rst = 1'b0;

        // R7: LE rises almost immediately after reset, no flag expected
        send_word(18'h3FFFF, 0, W, 1'b0);
        // R2: filler bits ahead of word
        send_word(18'h20000, 5, 2, 1'b0);
        check(lo_seen == 0, "R7 no low-dwell flag after reset", 32'(lo_seen), 32'd0);
        send_word(18'h1FFFF, 30, 3, 1'b0);
        send_word(18'h2A5C3, 0, 4, 1'b0);
        // R5: LE high on a single edge
        send_word(18'h00001, 7, 1, 1'b1);
        // R6: LE low on a single edge (the fall edge) before rising
        send_word(18'h12345, 0, 17, 1'b0);
        lo_expected++;

        // R4: LE held low over many bits; only the pending fall happens
        for (int i = 0; i < 40; i++) shift_bit(1'($urandom), 1'b0);
        @(negedge clk);
        check(sb_q.size() == 0, "R3 pending word delivered", 32'(sb_q.size()), 32'd0);
        held = word_out;
        check(held == 18'h12345, "R4 value after low hold", 32'(held), 32'h12345);

        // R4: LE held high over many bits, then a word; last 18 kept (R2)
        for (int i = 0; i < 30; i++) shift_bit(1'($urandom), 1'b1);
        @(negedge clk);
        check(word_out == held, "R4 value during high hold", 32'(word_out), 32'(held));
        send_word(18'h0F0F1, 0, W, 1'b0);

        // final fall and flush
        for (int i = 0; i < 4; i++) shift_bit(1'b0, 1'b0);
        repeat (2) @(negedge clk);
        check(sb_q.size() == 0, "R3 all words delivered", 32'(sb_q.size()), 32'd0);
        check(lo_seen == lo_expected, "R6 low-dwell flag count", 32'(lo_seen), 32'(lo_expected));

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule